// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block converts one instruction operand into the data value it denotes and, where the operand names a memory location, the effective address of that location. An operand is a 4-bit mode nibble plus a 20-bit field. A single `start` pulse hands the operand to the unit. The unit then uses three sources as the mode requires: the field itself, a read port into the register file, and up to two dependent reads through a memory port. When it finishes, it raises `done` for one cycle, together with the value, the address and an error flag.

The unit supports six modes, grouped in two families. The memory family has four: immediate (the field is the value), direct (the field is an address), pointer (the field is the address of an address), and stack index (the stack pointer minus the field, modulo 2^20, is the address of an address). The register family has two, each selected by setting the top bit of the nibble: register direct returns the register contents, and register indirect reads memory once at the address held in the register. Register id 0 is the stack pointer itself. Any other nibble is rejected with an error and no memory traffic. Instruction decode, register write-back and the memory are outside this block.

Top module: `operand_resolver`

## Requirements
- R1: Mode 4'h0 (immediate) completes with `value` equal to the field, `addr_valid` low, `error` low, no memory request, and `done` high in the second cycle after the `start` cycle.
- R2: Mode 4'h1 (direct) makes one memory read at the field address and completes with `value` equal to the returned word and `eff_addr` equal to the field, with `addr_valid` high.
- R3: Mode 4'h2 (pointer) reads at the field address, then reads at the returned word, and completes with `value` equal to the second word and `eff_addr` equal to the first word.
- R4: Mode 4'h3 (stack index) forms the first address as `sp` minus the field, wrapping modulo 2^20, and then proceeds exactly as mode 4'h2.
- R5: Mode 4'h8 (register direct) drives `rf_id` with the field's low 4 bits and returns `rf_data`, or `sp` when the id is 0. It makes no memory request, leaves `addr_valid` low and completes with the same latency as R1.
- R6: Mode 4'h9 (register indirect) makes one memory read at the register contents (with id 0 selecting `sp`) and completes with that word as `value` and the register contents as `eff_addr`.
- R7: Mode values 4'h4 to 4'h7 and 4'hA to 4'hF complete with `error` high, `addr_valid` low, no memory request and the same latency as R1.
- R8: `mem_req` stays high, with `mem_addr` stable, until a cycle in which `mem_valid` is high. Only one read is outstanding at a time, and a `mem_valid` that arrives while `mem_req` is low has no effect on any output.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after `start` until the completion edge. A `start` while `busy` is ignored. `value`, `eff_addr`, `addr_valid` and `error` hold their values until the next completion.
- R10: After reset, `busy`, `done`, `error`, `addr_valid` and `mem_req` are low and `value` and `eff_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept an operand (taken only when not busy) |
| op_mode | input | 4 | Addressing mode nibble |
| op_field | input | 20 | Operand field: value, address or register id |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operand had an illegal mode |
| value | output | 20 | Resolved data value |
| eff_addr | output | 20 | Effective address of the value (0 when none) |
| addr_valid | output | 1 | `eff_addr` names a memory location |
| mem_req | output | 1 | Memory read request, held until valid |
| mem_addr | output | 20 | Memory read address |
| mem_valid | input | 1 | Read data valid, completes the held request |
| mem_rdata | input | 20 | Read data |
| rf_id | output | 4 | Register file read id |
| rf_data | input | 20 | Register file read data |
| sp | input | 20 | Current stack pointer |

## Verification
The assertions check the memory handshake on every cycle: the request holds with a stable address until valid, and it is raised only while busy. They also check that `done` is a lone pulse seen only when idle, that immediate and direct completions carry the field as value or address, and that illegal and register-direct operands complete without a request in the cycle before. The bench's scenarios are needed for everything that involves data: chained pointer reads, the stack-index wrap below zero, and the stack-pointer substitution for register id 0. The scenarios also cover the completion latency, a `start` ignored while busy, and stray `mem_valid` pulses ignored while idle. For these the bench sweeps every mode nibble against boundary fields, two stack pointers and varying memory latency, and checks each result against an arithmetic memory model.

// File: rtl/opres_pkg.sv
// Shared encodings for the operand resolver.
// Assumes a 4-bit mode nibble; the register family sets the nibble's MSB.
package opres_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_IMM  = 4'h0;
    localparam logic [MODE_W-1:0] MODE_DIR  = 4'h1;
    localparam logic [MODE_W-1:0] MODE_PTR  = 4'h2;
    localparam logic [MODE_W-1:0] MODE_STK  = 4'h3;
    localparam logic [MODE_W-1:0] MODE_REG  = 4'h8;
    localparam logic [MODE_W-1:0] MODE_RIND = 4'h9;

    typedef enum logic [2:0] {
        KIND_IMM,
        KIND_DIR,
        KIND_PTR,
        KIND_STK,
        KIND_REG,
        KIND_RIND,
        KIND_BAD
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FIRST,
        ST_SECOND
    } state_t;
endpackage

// File: rtl/opres_decode.sv
// Classifies a mode nibble into an operand kind.
// Assumes nothing about the field; purely combinational.
module opres_decode
    import opres_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output kind_t             kind,
    output logic              chained
);
    // Map each legal nibble to its kind; everything else is illegal.
    always_comb begin
        unique case (mode)
            MODE_IMM:  kind = KIND_IMM;
            MODE_DIR:  kind = KIND_DIR;
            MODE_PTR:  kind = KIND_PTR;
            MODE_STK:  kind = KIND_STK;
            MODE_REG:  kind = KIND_REG;
            MODE_RIND: kind = KIND_RIND;
            default:   kind = KIND_BAD;
        endcase
    end

    // Pointer and stack-index kinds need a second, dependent read.
    always_comb begin
        chained = (kind == KIND_PTR) || (kind == KIND_STK);
    end
endmodule

// File: rtl/opres_reg_select.sv
// Register read port front end: drives the id and substitutes the stack
// pointer for its reserved id. Assumes the register file answers combinationally.
module opres_reg_select #(
    parameter int DATA_W   = 20,
    parameter int REG_ID_W = 4,
    parameter int SP_ID    = 0
) (
    input  logic [REG_ID_W-1:0] id_in,
    input  logic [DATA_W-1:0]   rf_data,
    input  logic [DATA_W-1:0]   sp,
    output logic [REG_ID_W-1:0] rf_id,
    output logic [DATA_W-1:0]   reg_val
);
    localparam logic [REG_ID_W-1:0] SP_ID_L = REG_ID_W'(SP_ID);

    // Forward the id and pick the register value source.
    always_comb begin
        rf_id   = id_in;
        reg_val = (id_in == SP_ID_L) ? sp : rf_data;
    end
endmodule

// File: rtl/opres_first_addr.sv
// Computes the address of the first memory read for a given kind.
// Assumes the stack-index subtraction wraps at the data width.
module opres_first_addr
    import opres_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  kind_t             kind,
    input  logic [DATA_W-1:0] field,
    input  logic [DATA_W-1:0] sp,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] first_addr
);
    // Select field, register contents or stack-relative difference.
    always_comb begin
        case (kind)
            KIND_STK:  first_addr = sp - field;
            KIND_RIND: first_addr = reg_val;
            default:   first_addr = field;
        endcase
    end
endmodule

// File: rtl/operand_resolver.sv
// Operand resolver top: latches an operand on start, evaluates it in one
// cycle, then performs up to two dependent memory reads with a held
// request/valid handshake. Assumes the memory completes a read by raising
// mem_valid while mem_req is high; only one read is ever outstanding.
module operand_resolver
    import opres_pkg::*;
#(
    parameter int DATA_W   = 20,
    parameter int REG_ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [MODE_W-1:0]   op_mode,
    input  logic [DATA_W-1:0]   op_field,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic [DATA_W-1:0]   value,
    output logic [DATA_W-1:0]   eff_addr,
    output logic                addr_valid,
    output logic                mem_req,
    output logic [DATA_W-1:0]   mem_addr,
    input  logic                mem_valid,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [REG_ID_W-1:0] rf_id,
    input  logic [DATA_W-1:0]   rf_data,
    input  logic [DATA_W-1:0]   sp
);
    state_t              state;
    logic [MODE_W-1:0]   mode_q;
    logic [DATA_W-1:0]   field_q;
    logic [DATA_W-1:0]   rd_addr_q;
    logic [DATA_W-1:0]   value_q;
    logic [DATA_W-1:0]   addr_q;
    logic                av_q;
    logic                err_q;
    logic                done_q;

    kind_t               kind;
    logic                chained;
    logic [DATA_W-1:0]   reg_val;
    logic [DATA_W-1:0]   first_addr;

    opres_decode u_decode (
        .mode    (mode_q),
        .kind    (kind),
        .chained (chained)
    );

    opres_reg_select #(
        .DATA_W   (DATA_W),
        .REG_ID_W (REG_ID_W),
        .SP_ID    (0)
    ) u_regsel (
        .id_in   (field_q[REG_ID_W-1:0]),
        .rf_data (rf_data),
        .sp      (sp),
        .rf_id   (rf_id),
        .reg_val (reg_val)
    );

    opres_first_addr #(
        .DATA_W (DATA_W)
    ) u_first (
        .kind       (kind),
        .field      (field_q),
        .sp         (sp),
        .reg_val    (reg_val),
        .first_addr (first_addr)
    );

    // Sequencer: accept, evaluate, read once or twice, then report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= '0;
            field_q   <= '0;
            rd_addr_q <= '0;
            value_q   <= '0;
            addr_q    <= '0;
            av_q      <= 1'b0;
            err_q     <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= op_mode;
                        field_q <= op_field;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    case (kind)
                        KIND_IMM: begin
                            value_q <= field_q;
                            addr_q  <= '0;
                            av_q    <= 1'b0;
                            err_q   <= 1'b0;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end
                        KIND_REG: begin
                            value_q <= reg_val;
                            addr_q  <= '0;
                            av_q    <= 1'b0;
                            err_q   <= 1'b0;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end
                        KIND_BAD: begin
                            value_q <= '0;
                            addr_q  <= '0;
                            av_q    <= 1'b0;
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end
                        default: begin
                            rd_addr_q <= first_addr;
                            state     <= ST_FIRST;
                        end
                    endcase
                end
                ST_FIRST: begin
                    if (mem_valid) begin
                        if (chained) begin
                            rd_addr_q <= mem_rdata;
                            state     <= ST_SECOND;
                        end else begin
                            value_q <= mem_rdata;
                            addr_q  <= rd_addr_q;
                            av_q    <= 1'b1;
                            err_q   <= 1'b0;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end
                    end
                end
                ST_SECOND: begin
                    if (mem_valid) begin
                        value_q <= mem_rdata;
                        addr_q  <= rd_addr_q;
                        av_q    <= 1'b1;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = (state == ST_FIRST) || (state == ST_SECOND);
        mem_addr   = rd_addr_q;
        done       = done_q;
        error      = err_q;
        value      = value_q;
        eff_addr   = addr_q;
        addr_valid = av_q;
    end
endmodule

// File: rtl/opres_checker.sv
// Cycle-level properties of the operand resolver, bound to its top.
// Assumes the synchronous active-low reset of the design.
module opres_checker
    import opres_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [DATA_W-1:0] value,
    input logic [DATA_W-1:0] eff_addr,
    input logic              addr_valid,
    input logic              mem_req,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic [MODE_W-1:0] mode_q,
    input logic [DATA_W-1:0] field_q
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req && $stable(mem_addr)); // R8
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_BAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done && error |-> !$past(mem_req) && !addr_valid); // R7
    AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_q == MODE_IMM |-> value == field_q && !addr_valid && !error); // R1
    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_q == MODE_DIR |-> eff_addr == field_q && addr_valid); // R2
    AST_REG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_q == MODE_REG |-> !$past(mem_req) && !addr_valid); // R5
endmodule

bind operand_resolver opres_checker #(.DATA_W(DATA_W)) u_opres_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .value      (value),
    .eff_addr   (eff_addr),
    .addr_valid (addr_valid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_valid  (mem_valid),
    .mode_q     (mode_q),
    .field_q    (field_q)
);

// File: tb/operand_resolver_tb.sv
// Sweeps every mode nibble over boundary fields, two stack pointers and
// varying memory latency against an arithmetic memory and register model.
module operand_resolver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 20;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op_mode = '0;
    logic [W-1:0]  op_field = '0;
    logic          busy, done, error, addr_valid, mem_req;
    logic [W-1:0]  value, eff_addr, mem_addr;
    logic          mem_valid = 1'b0;
    logic [W-1:0]  mem_rdata = '0;
    logic [3:0]    rf_id;
    logic [W-1:0]  rf_data;
    logic [W-1:0]  sp = '0;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int wait_cnt = 0;
    logic stray = 1'b0;
    int n_reads = 0;
    int n_done = 0;
    int cycles = 0;

    operand_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_mode(op_mode),
        .op_field(op_field), .busy(busy), .done(done), .error(error),
        .value(value), .eff_addr(eff_addr), .addr_valid(addr_valid),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .rf_id(rf_id), .rf_data(rf_data), .sp(sp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] mem_f(input logic [W-1:0] a);
        return a * 20'd7 + 20'h0B3C5;
    endfunction

    function automatic logic [W-1:0] reg_f(input logic [3:0] id);
        return ({16'b0, id} * 20'h01111) ^ 20'hA0005;
    endfunction

    assign rf_data = reg_f(rf_id);

    // Memory model: answers a held request after lat cycles; stray pulses when idle.
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = mem_f(mem_addr);
                wait_cnt  = 0;
            end else begin
                mem_valid = 1'b0;
                wait_cnt  = wait_cnt + 1;
            end
        end else begin
            mem_valid = stray;
            mem_rdata = 20'h5A5A5;
            wait_cnt  = 0;
        end
    end

    // Count completed reads, done pulses and cycles; watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req && mem_valid) n_reads <= n_reads + 1;
        if (done) n_done <= n_done + 1;
        if (cycles > WATCHDOG) begin
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            n_bad = n_bad + 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2: return "R3";
            4'h3: return "R4";
            4'h8: return "R5";
            4'h9: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Run one operand from a negedge; returns at the negedge after completion.
    task automatic run_op(input logic [3:0] m, input logic [W-1:0] f);
        int n = 0;
        int reads0;
        logic [W-1:0] exp_v, exp_a, a1, r;
        logic exp_av, exp_err;
        int exp_reads;
        string t;
        t = req_of(m);
        reads0 = n_reads;
        op_mode = m;
        op_field = f;
        start = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                chk("R9 busy after start", {31'b0, busy}, 32'd1);
            end
        end while (!done && n < 100);
        r = (f[3:0] == 4'h0) ? sp : reg_f(f[3:0]);
        exp_v = '0; exp_a = '0; exp_av = 1'b0; exp_err = 1'b0; exp_reads = 0;
        case (m)
            4'h0: exp_v = f;
            4'h1: begin exp_v = mem_f(f); exp_a = f; exp_av = 1'b1; exp_reads = 1; end
            4'h2: begin a1 = mem_f(f); exp_v = mem_f(a1); exp_a = a1; exp_av = 1'b1; exp_reads = 2; end
            4'h3: begin a1 = mem_f(sp - f); exp_v = mem_f(a1); exp_a = a1; exp_av = 1'b1; exp_reads = 2; end
            4'h8: exp_v = r;
            4'h9: begin exp_v = mem_f(r); exp_a = r; exp_av = 1'b1; exp_reads = 1; end
            default: exp_err = 1'b1;
        endcase
        chk({t, " done seen"}, {31'b0, done}, 32'd1);
        chk({t, " error"}, {31'b0, error}, {31'b0, exp_err});
        chk({t, " addr_valid"}, {31'b0, addr_valid}, {31'b0, exp_av});
        chk({t, " reads"}, n_reads - reads0, exp_reads);
        if (!exp_err) chk({t, " value"}, {12'b0, value}, {12'b0, exp_v});
        if (exp_av) chk({t, " eff_addr"}, {12'b0, eff_addr}, {12'b0, exp_a});
        if (exp_reads == 0) chk({t, " latency"}, n, 2);
        @(negedge clk);
        chk("R9 done single pulse", {31'b0, done}, 32'd0);
        chk("R9 held value", {12'b0, value}, exp_err ? 32'd0 : {12'b0, exp_v});
    endtask

    initial begin
        logic [W-1:0] fields [6];
        logic [W-1:0] sps [2];
        int idx = 0;
        int d0;
        logic [W-1:0] hold_v, hold_a;
        fields[0] = 20'h00000; fields[1] = 20'h00001; fields[2] = 20'h00005;
        fields[3] = 20'h12345; fields[4] = 20'hFFFFF; fields[5] = 20'h80003;
        sps[0] = 20'h00003; sps[1] = 20'hFFA10;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'b0, busy}, 32'd0);
        chk("R10 done", {31'b0, done}, 32'd0);
        chk("R10 error", {31'b0, error}, 32'd0);
        chk("R10 addr_valid", {31'b0, addr_valid}, 32'd0);
        chk("R10 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R10 value", {12'b0, value}, 32'd0);
        chk("R10 eff_addr", {12'b0, eff_addr}, 32'd0);

        // Full sweep; stack index with sp=3 and field 5 wraps below zero (R4).
        for (int s = 0; s < 2; s++) begin
            sp = sps[s];
            for (int m = 0; m < 16; m++) begin
                for (int k = 0; k < 6; k++) begin
                    lat = idx % 4;
                    idx++;
                    run_op(m[3:0], fields[k]);
                end
            end
        end

        // R8: stray mem_valid while idle changes nothing.
        hold_v = value; hold_a = eff_addr;
        d0 = n_done;
        stray = 1'b1;
        repeat (8) @(negedge clk);
        stray = 1'b0;
        @(negedge clk);
        chk("R8 stray value", {12'b0, value}, {12'b0, hold_v});
        chk("R8 stray eff_addr", {12'b0, eff_addr}, {12'b0, hold_a});
        chk("R8 stray no done", n_done - d0, 0);
        chk("R8 stray no busy", {31'b0, busy}, 32'd0);

        // R9: start during a slow pointer resolution is ignored.
        sp = 20'h00010;
        lat = 3;
        d0 = n_done;
        op_mode = 4'h2; op_field = 20'h12345; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        op_mode = 4'h0; op_field = 20'h55555; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        chk("R9 ignored start value", {12'b0, value}, {12'b0, mem_f(mem_f(20'h12345))});
        chk("R3 ignored start eff_addr", {12'b0, eff_addr}, {12'b0, mem_f(20'h12345)});
        repeat (5) @(negedge clk);
        chk("R9 single completion", n_done - d0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule